// File: doc/BRIEF.md
# PLL Reconfiguration Sequencer

This block walks a clock generator through a safe retune. A start pulse, given while the requesting master holds the clock-configuration ownership grant, latches four things: a new PLL multiplier, a final divider value, a lock timeout and a flag saying whether this master must power the PLL down. The block then drives the bypass, power-down, multiplier and divider controls through a fixed series of steps. Each step is one registered write, so every control change is visible for at least one cycle before the next one happens.

The series runs as follows. The PLL is bypassed. If the flag asks for it, the PLL is powered down. The dividers are raised to their slowest setting. The new multiplier is loaded. Power is restored. The block then waits for the lock input and removes the bypass once lock is seen. Last, the final divider value is applied. The lock input passes through a two-flop synchronizer. A lock indication that is still high from before the change is ignored during a short settle window. If lock does not arrive within the programmed timeout, the block stops with the PLL still bypassed and raises an error flag. The block is used by firmware or a control agent that has already taken ownership of the clock registers; it does not arbitrate for that ownership itself.

Top module: `pll_reseq`

## Requirements
- R1: A start pulse is accepted only while the block is idle and `grant_i` is 1. A start with `grant_i` at 0 is ignored: busy stays 0 and no control output changes.
- R2: The first visible effect of an accepted start is `pll_bypass_o` going to 1, one cycle after the accepting edge. Busy is 1 from the accepting edge until the run ends.
- R3: When the captured power-down flag is 1, `pll_pwrdn_o` goes to 1 one cycle after the bypass and before the dividers change. When the flag is 0, `pll_pwrdn_o` stays 0 for the whole run.
- R4: `clk_div_o` is set to all ones (the slowest setting) one cycle before the new multiplier appears on `pll_mult_o`. The multiplier changes only while the bypass is 1.
- R5: `pll_pwrdn_o` returns to 0 one cycle after the new multiplier is loaded, and never earlier.
- R6: The lock input is used only after a two-flop synchronizer. It is also ignored for the first SETTLE_CYC cycles of the lock wait. The bypass is removed only after that, on a synchronized lock.
- R7: One cycle after the bypass is removed, `clk_div_o` takes the captured final divider value. In the same cycle `done_o` pulses high for exactly one cycle and busy falls.
- R8: If no usable lock is seen, `err_tmo_o` rises tmo+1 cycles after the lock wait begins. The lock wait begins one cycle after the power-on step. At that point busy falls, no done pulse occurs and `pll_bypass_o` stays 1. The error flag stays set until the next accepted start clears it.
- R9: A start pulse while busy is ignored: the multiplier and divider captured at the accepting start are the ones applied.
- R10: After reset: bypass 0, power-down 0, multiplier equal to MULT_RST, divider equal to DIV_RST, and busy, done and error all 0.
- R11: With power-down, the steps appear at cycles +1 (bypass), +2 (power-down), +3 (divider max), +4 (multiplier), +5 (power-on) after the accepting edge. Without power-down, the power-down step is skipped and every later step moves one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request pulse |
| grant_i | input | 1 | Requesting master holds clock-register ownership |
| pd_req_i | input | 1 | 1 = PLL must be powered down during the change |
| mult_i | input | MULT_W | New PLL multiplier |
| div_i | input | DIV_W | Final divider value |
| tmo_i | input | TMO_W | Lock wait timeout in cycles |
| lock_i | input | 1 | Asynchronous PLL lock indication |
| pll_bypass_o | output | 1 | 1 = PLL bypassed |
| pll_pwrdn_o | output | 1 | 1 = PLL powered down |
| pll_mult_o | output | MULT_W | PLL multiplier |
| clk_div_o | output | DIV_W | Clock divider |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse on success |
| err_tmo_o | output | 1 | Lock timeout flag |

## Verification
A wrong step state shows at the control ports within one cycle. Each step is a single registered write placed at a fixed offset from the accepting edge, so a skipped, repeated or reordered step moves a bypass, power-down, divider or multiplier edge off its expected cycle. A fault in the lock path or the timer shows up at one of three points: the bypass edge, the error edge at tmo+1 cycles into the wait, or the missing done pulse. A stale lock honoured too early shows as the bypass being removed before the modelled PLL could have locked again.

// File: rtl/pll_reseq_pkg.sv
// Package: shared types for the PLL reconfiguration sequencer.
// Assumes: one step command is active per cycle.
package pll_reseq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BYP,
        ST_PDN,
        ST_DMAX,
        ST_MUL,
        ST_PUP,
        ST_LOCK,
        ST_UNB,
        ST_FDIV
    } step_e;

    typedef struct packed {
        logic accept;
        logic set_byp;
        logic set_pdn;
        logic set_dmax;
        logic set_mul;
        logic clr_pdn;
        logic clr_byp;
        logic set_fdiv;
        logic fail;
    } step_cmd_t;

endpackage

// File: rtl/pll_lock_sync.sv
// Module: pll_lock_sync
// Brings the asynchronous lock indication into the clock domain through
// a chain of STAGES flops. Assumes lock_i is a level that is stable for
// several cycles when it changes.
module pll_lock_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_i,
    output logic lock_s_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the lock level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], lock_i};
        end
    end

    assign lock_s_o = chain_q[STAGES-1];

endmodule

// File: rtl/pll_lock_timer.sv
// Module: pll_lock_timer
// Counts cycles spent in the lock wait. It flags when the settle window
// has passed and when the programmed timeout has been reached.
// Assumes run_i is held high for the whole wait and low otherwise.
module pll_lock_timer #(
    parameter int TMO_W      = 16,
    parameter int SETTLE_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [TMO_W-1:0] tmo_i,
    output logic             settled_o,
    output logic             expired_o
);

    localparam logic [TMO_W-1:0] CNT_MAX    = '1;
    localparam logic [TMO_W-1:0] SETTLE_VAL = TMO_W'(SETTLE_CYC);

    logic [TMO_W-1:0] cnt_q;

    // Clear outside the wait, count (saturating) inside it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign settled_o = run_i && (cnt_q >= SETTLE_VAL);
    assign expired_o = run_i && (cnt_q == tmo_i);

endmodule

// File: rtl/pll_step_fsm.sv
// Module: pll_step_fsm
// Walks the fixed step order and issues one step command per cycle.
// Assumes the output registers act on each command at the next edge.
// The power-down step is taken only when pd_i is set.
module pll_step_fsm
    import pll_reseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    input  logic      grant_i,
    input  logic      pd_i,
    input  logic      lock_s_i,
    input  logic      settled_i,
    input  logic      expired_i,
    output step_cmd_t cmd_o,
    output logic      wait_o,
    output logic      busy_o
);

    step_e state_q;
    step_e state_d;
    logic  lock_ok;

    assign lock_ok = lock_s_i && settled_i;

    // Next-state and command decode for the current step.
    always_comb begin
        state_d = state_q;
        cmd_o   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i && grant_i) begin
                    cmd_o.accept = 1'b1;
                    state_d      = ST_BYP;
                end
            end
            ST_BYP: begin
                cmd_o.set_byp = 1'b1;
                state_d       = pd_i ? ST_PDN : ST_DMAX;
            end
            ST_PDN: begin
                cmd_o.set_pdn = 1'b1;
                state_d       = ST_DMAX;
            end
            ST_DMAX: begin
                cmd_o.set_dmax = 1'b1;
                state_d        = ST_MUL;
            end
            ST_MUL: begin
                cmd_o.set_mul = 1'b1;
                state_d       = ST_PUP;
            end
            ST_PUP: begin
                cmd_o.clr_pdn = 1'b1;
                state_d       = ST_LOCK;
            end
            ST_LOCK: begin
                if (lock_ok) begin
                    state_d = ST_UNB;
                end else if (expired_i) begin
                    cmd_o.fail = 1'b1;
                    state_d    = ST_IDLE;
                end
            end
            ST_UNB: begin
                cmd_o.clr_byp = 1'b1;
                state_d       = ST_FDIV;
            end
            ST_FDIV: begin
                cmd_o.set_fdiv = 1'b1;
                state_d        = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Advance the step register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign wait_o = (state_q == ST_LOCK);
    assign busy_o = (state_q != ST_IDLE);

endmodule

// File: rtl/pll_out_regs.sv
// Module: pll_out_regs
// Holds the captured request and the registered control outputs. Each
// step command changes exactly one control at the next edge.
// Assumes at most one command bit is set per cycle.
module pll_out_regs
    import pll_reseq_pkg::*;
#(
    parameter int MULT_W = 8,
    parameter int DIV_W  = 4,
    parameter int TMO_W  = 16,
    parameter logic [MULT_W-1:0] MULT_RST = 1,
    parameter logic [DIV_W-1:0]  DIV_RST  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  step_cmd_t         cmd_i,
    input  logic              pd_req_i,
    input  logic [MULT_W-1:0] mult_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [TMO_W-1:0]  tmo_i,
    output logic              pd_q_o,
    output logic [TMO_W-1:0]  tmo_q_o,
    output logic              bypass_o,
    output logic              pwrdn_o,
    output logic [MULT_W-1:0] mult_o,
    output logic [DIV_W-1:0]  div_o,
    output logic              done_o,
    output logic              err_o
);

    localparam logic [DIV_W-1:0] DIV_MAX = '1;

    logic [MULT_W-1:0] mult_req_q;
    logic [DIV_W-1:0]  div_req_q;

    // Capture the request fields at the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_q_o     <= 1'b0;
            tmo_q_o    <= '0;
            mult_req_q <= MULT_RST;
            div_req_q  <= DIV_RST;
        end else if (cmd_i.accept) begin
            pd_q_o     <= pd_req_i;
            tmo_q_o    <= tmo_i;
            mult_req_q <= mult_i;
            div_req_q  <= div_i;
        end
    end

    // Bypass control: set at the first step, cleared after lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bypass_o <= 1'b0;
        end else if (cmd_i.set_byp) begin
            bypass_o <= 1'b1;
        end else if (cmd_i.clr_byp) begin
            bypass_o <= 1'b0;
        end
    end

    // Power-down control: set on the optional step, cleared at power-on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwrdn_o <= 1'b0;
        end else if (cmd_i.set_pdn) begin
            pwrdn_o <= 1'b1;
        end else if (cmd_i.clr_pdn) begin
            pwrdn_o <= 1'b0;
        end
    end

    // Multiplier control: loads the captured value at its step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mult_o <= MULT_RST;
        end else if (cmd_i.set_mul) begin
            mult_o <= mult_req_q;
        end
    end

    // Divider control: slowest setting first, final value last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_o <= DIV_RST;
        end else if (cmd_i.set_dmax) begin
            div_o <= DIV_MAX;
        end else if (cmd_i.set_fdiv) begin
            div_o <= div_req_q;
        end
    end

    // Completion pulse and sticky timeout flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            done_o <= cmd_i.set_fdiv;
            if (cmd_i.accept) begin
                err_o <= 1'b0;
            end else if (cmd_i.fail) begin
                err_o <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pll_reseq.sv
// Module: pll_reseq (top)
// PLL reconfiguration sequencer. Links the lock synchronizer, the
// lock-wait timer, the step state machine and the output registers.
// Assumes ownership of the clock registers is signalled on grant_i and
// that lock_i comes from another timing domain.
module pll_reseq
    import pll_reseq_pkg::*;
#(
    parameter int MULT_W      = 8,
    parameter int DIV_W       = 4,
    parameter int TMO_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int SETTLE_CYC  = 4,
    parameter logic [MULT_W-1:0] MULT_RST = 1,
    parameter logic [DIV_W-1:0]  DIV_RST  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              grant_i,
    input  logic              pd_req_i,
    input  logic [MULT_W-1:0] mult_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [TMO_W-1:0]  tmo_i,
    input  logic              lock_i,
    output logic              pll_bypass_o,
    output logic              pll_pwrdn_o,
    output logic [MULT_W-1:0] pll_mult_o,
    output logic [DIV_W-1:0]  clk_div_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_tmo_o
);

    step_cmd_t        cmd;
    logic             lock_s;
    logic             settled;
    logic             expired;
    logic             in_wait;
    logic             pd_q;
    logic [TMO_W-1:0] tmo_q;

    pll_lock_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_i   (lock_i),
        .lock_s_o (lock_s)
    );

    pll_lock_timer #(
        .TMO_W      (TMO_W),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (in_wait),
        .tmo_i     (tmo_q),
        .settled_o (settled),
        .expired_o (expired)
    );

    pll_step_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .grant_i   (grant_i),
        .pd_i      (pd_q),
        .lock_s_i  (lock_s),
        .settled_i (settled),
        .expired_i (expired),
        .cmd_o     (cmd),
        .wait_o    (in_wait),
        .busy_o    (busy_o)
    );

    pll_out_regs #(
        .MULT_W   (MULT_W),
        .DIV_W    (DIV_W),
        .TMO_W    (TMO_W),
        .MULT_RST (MULT_RST),
        .DIV_RST  (DIV_RST)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_i    (cmd),
        .pd_req_i (pd_req_i),
        .mult_i   (mult_i),
        .div_i    (div_i),
        .tmo_i    (tmo_i),
        .pd_q_o   (pd_q),
        .tmo_q_o  (tmo_q),
        .bypass_o (pll_bypass_o),
        .pwrdn_o  (pll_pwrdn_o),
        .mult_o   (pll_mult_o),
        .div_o    (clk_div_o),
        .done_o   (done_o),
        .err_o    (err_tmo_o)
    );

endmodule

// File: rtl/pll_reseq_chk.sv
// Module: pll_reseq_chk
// Port-level checker for pll_reseq, attached with bind below.
// Assumes synchronous active-low reset on rst_n.
module pll_reseq_chk #(
    parameter int MULT_W = 8,
    parameter int DIV_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              grant_i,
    input logic              pll_bypass_o,
    input logic              pll_pwrdn_o,
    input logic [MULT_W-1:0] pll_mult_o,
    input logic [DIV_W-1:0]  clk_div_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_tmo_o
);

    localparam logic [DIV_W-1:0] DIV_MAX = '1;

    // R1: idle start without grant leaves the block idle.
    a_r1_no_grant_no_run: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && !grant_i) |=> !busy_o);

    // R3: power-down only ever rises while the PLL is bypassed.
    a_r3_pwrdn_under_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_pwrdn_o) |-> (pll_bypass_o && busy_o));

    // R4: multiplier changes only while bypassed and divider at max.
    a_r4_mult_safe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pll_mult_o) |-> (pll_bypass_o && clk_div_o == DIV_MAX));

    // R6: bypass is removed only with the PLL powered.
    a_r6_unbypass_powered: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_bypass_o) |-> (!pll_pwrdn_o && busy_o));

    // R7: done pulse lasts one cycle and comes with the PLL in the path.
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r7_done_unbypassed: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!pll_bypass_o && !busy_o && !err_tmo_o));

    // R8: a timeout leaves the PLL bypassed and the block idle.
    a_r8_timeout_bypassed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_tmo_o) |-> (pll_bypass_o && !busy_o && !done_o));

endmodule

bind pll_reseq pll_reseq_chk #(
    .MULT_W (MULT_W),
    .DIV_W  (DIV_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .grant_i      (grant_i),
    .pll_bypass_o (pll_bypass_o),
    .pll_pwrdn_o  (pll_pwrdn_o),
    .pll_mult_o   (pll_mult_o),
    .clk_div_o    (clk_div_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_tmo_o    (err_tmo_o)
);

// File: tb/sim_pll_reseq.sv
`timescale 1ns/1ps
// Bench: directed tests for pll_reseq, one task per scenario.
module sim_pll_reseq;

    localparam int LOCK_DLY = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        grant_i = 1'b0;
    logic        pd_req_i = 1'b0;
    logic [7:0]  mult_i = '0;
    logic [3:0]  div_i = '0;
    logic [15:0] tmo_i = '0;
    logic        lock_i;
    logic        pll_bypass_o, pll_pwrdn_o, busy_o, done_o, err_tmo_o;
    logic [7:0]  pll_mult_o;
    logic [3:0]  clk_div_o;

    int n_chk = 0;
    int n_bad = 0;
    logic lock_blk = 1'b0;

    always #2.5 clk = ~clk;

    pll_reseq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .grant_i(grant_i),
        .pd_req_i(pd_req_i), .mult_i(mult_i), .div_i(div_i), .tmo_i(tmo_i),
        .lock_i(lock_i), .pll_bypass_o(pll_bypass_o), .pll_pwrdn_o(pll_pwrdn_o),
        .pll_mult_o(pll_mult_o), .clk_div_o(clk_div_o), .busy_o(busy_o),
        .done_o(done_o), .err_tmo_o(err_tmo_o)
    );

    // PLL model: loses lock on power-down, on a multiplier change or when
    // blocked, and regains it LOCK_DLY cycles later.
    logic [7:0] prev_mult;
    int         lk_cnt;
    always @(posedge clk) begin
        if (!rst_n) begin
            lk_cnt    <= 0;
            lock_i    <= 1'b0;
            prev_mult <= pll_mult_o;
        end else begin
            prev_mult <= pll_mult_o;
            if (pll_pwrdn_o || lock_blk || pll_mult_o != prev_mult) begin
                lk_cnt <= 0;
                lock_i <= 1'b0;
            end else if (lk_cnt >= LOCK_DLY) begin
                lock_i <= 1'b1;
            end else begin
                lk_cnt <= lk_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    // Event cycles recorded by run_seq (offsets from the accepting edge).
    int t_byp, t_pd, t_dm, t_ml, t_pu, t_ub, t_fd, t_dn, t_err, n_done;

    task automatic run_seq(input bit pd, input logic [7:0] m, input logic [3:0] d,
                           input logic [15:0] t, input int release_n, input bit poke);
        t_byp = -1; t_pd = -1; t_dm = -1; t_ml = -1; t_pu = -1;
        t_ub = -1; t_fd = -1; t_dn = -1; t_err = -1; n_done = 0;
        @(negedge clk);
        grant_i = 1'b1; pd_req_i = pd; mult_i = m; div_i = d; tmo_i = t;
        start_i = 1'b1;
        for (int n = 0; n < 600; n++) begin
            @(negedge clk);
            start_i = 1'b0;
            if (n == release_n) lock_blk = 1'b0;
            if (poke && n == 2) begin start_i = 1'b1; mult_i = m + 8'd5; div_i = d + 4'd1; end
            if (t_byp < 0 && pll_bypass_o) t_byp = n;
            if (t_pd < 0 && pll_pwrdn_o) t_pd = n;
            if (t_dm < 0 && clk_div_o == 4'hF) t_dm = n;
            if (t_ml < 0 && pll_mult_o == m) t_ml = n;
            if (t_pu < 0 && t_ml >= 0 && !pll_pwrdn_o) t_pu = n;
            if (t_ub < 0 && t_byp >= 0 && !pll_bypass_o) t_ub = n;
            if (t_fd < 0 && t_ub >= 0 && clk_div_o == d) t_fd = n;
            if (done_o) begin n_done++; if (t_dn < 0) t_dn = n; end
            if (t_err < 0 && err_tmo_o) t_err = n;
            if (!busy_o && n > 0) begin
                @(negedge clk);
                if (done_o) n_done++;
                break;
            end
        end
        start_i = 1'b0;
    endtask

    task automatic t_reset();
        chk(pll_bypass_o == 1'b0, "R10 bypass", pll_bypass_o, 0);
        chk(pll_pwrdn_o == 1'b0, "R10 pwrdn", pll_pwrdn_o, 0);
        chk(pll_mult_o == 8'd1, "R10 mult", pll_mult_o, 1);
        chk(clk_div_o == 4'd0, "R10 div", clk_div_o, 0);
        chk({busy_o, done_o, err_tmo_o} == 3'b000, "R10 flags",
            {busy_o, done_o, err_tmo_o}, 0);
    endtask

    task automatic t_no_grant();
        @(negedge clk);
        grant_i = 1'b0; mult_i = 8'd77; div_i = 4'd3; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        chk(!busy_o, "R1 busy without grant", busy_o, 0);
        chk(!pll_bypass_o && pll_mult_o == 8'd1, "R1 outputs untouched", pll_mult_o, 1);
    endtask

    task automatic t_run_pd();
        run_seq(1'b1, 8'd20, 4'd2, 16'd100, -1, 1'b0);
        chk(t_byp == 1, "R2 bypass cycle", t_byp, 1);
        chk(t_pd == 2, "R3 pwrdn cycle", t_pd, 2);
        chk(t_dm == 3, "R4 div max cycle", t_dm, 3);
        chk(t_ml == 4, "R11 mult cycle", t_ml, 4);
        chk(t_pu == 5, "R5 power-on cycle", t_pu, 5);
        chk(t_ub >= t_pu + LOCK_DLY, "R6 unbypass after lock", t_ub, t_pu + LOCK_DLY);
        chk(t_fd == t_ub + 1, "R7 final div cycle", t_fd, t_ub + 1);
        chk(t_dn == t_fd && n_done == 1, "R7 done pulse", n_done, 1);
        chk(clk_div_o == 4'd2 && pll_mult_o == 8'd20, "R7 final values", clk_div_o, 2);
    endtask

    task automatic t_run_nopd_poke();
        run_seq(1'b0, 8'd33, 4'd5, 16'd100, -1, 1'b1);
        chk(t_byp == 1, "R2 bypass cycle no-pd", t_byp, 1);
        chk(t_pd == -1, "R3 no pwrdn when flag 0", t_pd, -1);
        chk(t_dm == 2 && t_ml == 3, "R11 shifted steps", t_ml, 3);
        chk(t_ub >= t_ml + LOCK_DLY, "R6 stale lock ignored", t_ub, t_ml + LOCK_DLY);
        chk(pll_mult_o == 8'd33, "R9 busy start ignored mult", pll_mult_o, 33);
        chk(clk_div_o == 4'd5, "R9 busy start ignored div", clk_div_o, 5);
        chk(n_done == 1, "R7 done once", n_done, 1);
    endtask

    task automatic t_late_lock();
        lock_blk = 1'b1;
        run_seq(1'b1, 8'd44, 4'd1, 16'd200, 30, 1'b0);
        chk(t_ub >= 30 + LOCK_DLY, "R6 waits for late lock", t_ub, 30 + LOCK_DLY);
        chk(t_err == -1 && n_done == 1, "R6 completes after lock", n_done, 1);
    endtask

    task automatic t_timeout();
        lock_blk = 1'b1;
        run_seq(1'b1, 8'd50, 4'd6, 16'd10, -1, 1'b0);
        chk(t_err == 16, "R8 timeout cycle", t_err, 16);
        chk(pll_bypass_o == 1'b1, "R8 bypass kept", pll_bypass_o, 1);
        chk(t_dn == -1 && !busy_o, "R8 no done", t_dn, -1);
        chk(clk_div_o == 4'hF, "R8 div left at max", clk_div_o, 15);
        lock_blk = 1'b0;
        run_seq(1'b0, 8'd60, 4'd4, 16'd100, -1, 1'b0);
        chk(!err_tmo_o && n_done == 1, "R8 error cleared by next start", err_tmo_o, 0);
        chk(pll_mult_o == 8'd60 && !pll_bypass_o, "R8 recovery run", pll_mult_o, 60);
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_grant();
        repeat (12) @(negedge clk);
        t_run_pd();
        t_run_nopd_poke();
        t_late_lock();
        t_timeout();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule